// File: doc/BRIEF.md
# Divergent Warp Fragment Merger

After a branch splits a warp, its threads continue in fragments: each fragment has one instruction address and a lane mask that marks which threads are present. This block holds a small pool of waiting fragments. It folds an incoming fragment into a waiting entry when both are at the same address and their lanes do not overlap. Lanes are positional: the thread with ID t always occupies lane t mod LANES, because its registers sit in that lane. A fragment therefore never moves to another lane, and a collision blocks the merge. Next to each lane the block records the ID of the warp that supplied the thread, so that issue can choose the correct register context.

Entries leave through a valid/ready output port. An entry that has every lane filled is offered first. An entry that is still partial is offered only when the pool has no free entry or when no fragment is arriving. In that case the oldest entry goes out.

Top module: `dwf_merger`

## Requirements
- R1: After reset the pool is empty, `out_valid` is 0 and `in_ready` is 1.
- R2: Mask bit i is lane i, and thread t sits in lane t mod LANES. A fragment with a nonzero mask whose address matches a waiting entry and whose mask ANDs to zero with that entry's mask is ORed into that entry. No bit changes position.
- R3: `out_wid` holds WID_W bits per lane, with lane i at bits [i*WID_W +: WID_W]. For each active lane it holds the `in_wid` of the fragment that supplied that lane. Inactive lanes read 0.
- R4: A fragment whose mask overlaps every same-address entry goes to a free entry of its own. The waiting entries keep their masks.
- R5: Fragments at different addresses are never combined.
- R6: When any entry has all lanes set, the output offers a full entry (the lowest-indexed one if there are several) ahead of any partial entry.
- R7: When no entry is full, a partial entry is offered only if `in_valid` is 0 or every entry is occupied. The entry offered is the one allocated earliest.
- R8: `in_ready` is 0 only when no entry is free and no mergeable entry exists. While the pool is full, the entry being offered at the output does not count as a merge target.
- R9: A fragment with an all-zero mask is accepted (`in_ready` is 1) and discarded, leaving the pool unchanged.
- R10: An offered entry stays on the output until `out_ready` is 1 at a clock edge. At that edge it is removed from the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming fragment present |
| in_ready | output | 1 | Fragment can be taken this cycle |
| in_pc | input | PC_W | Fragment instruction address |
| in_mask | input | LANES | Fragment lane mask |
| in_wid | input | WID_W | ID of the warp the fragment came from |
| out_valid | output | 1 | Entry offered for issue |
| out_ready | input | 1 | Issue accepts the offered entry |
| out_pc | output | PC_W | Offered instruction address |
| out_mask | output | LANES | Offered lane mask |
| out_wid | output | LANES*WID_W | Per-lane source warp IDs |

## Verification
The assertions assume that the source holds `in_valid` high only while it presents a complete, stable fragment. They also assume that `out_ready` is driven to a known level on every cycle after reset. The bench changes inputs only on the falling clock edge, so each fragment is stable through the rising edge that accepts it. It drops `in_valid` explicitly whenever it wants partial entries to drain. Thread-to-lane masks in the bench are computed from thread IDs rather than written by hand.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  localparam int DWF_LANES   = 4;
  localparam int DWF_ENTRIES = 4;
  localparam int DWF_PC_W    = 16;
  localparam int DWF_WID_W   = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_FULL   = 2'd1,
    SEL_OLDEST = 2'd2
  } sel_kind_e;
endpackage

// File: rtl/dwf_match.sv
module dwf_match #(
  parameter int ENTRIES = 4,
  parameter int LANES   = 4,
  parameter int PC_W    = 16
) (
  input  logic [ENTRIES-1:0]            ent_vld,
  input  logic [ENTRIES-1:0][PC_W-1:0]  ent_pc,
  input  logic [ENTRIES-1:0][LANES-1:0] ent_mask,
  input  logic [ENTRIES-1:0]            excl,
  input  logic [PC_W-1:0]               in_pc,
  input  logic [LANES-1:0]              in_mask,
  output logic [ENTRIES-1:0]            hit,
  output logic [ENTRIES-1:0]            full
);
  localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit[e]  = ent_vld[e] && !excl[e] && (ent_pc[e] == in_pc)
                     && ((ent_mask[e] & in_mask) == '0);
    assign full[e] = ent_vld[e] && (ent_mask[e] == ALL_LANES);
  end
endmodule

// File: rtl/dwf_prio.sv
module dwf_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  assign gnt = req & (~req + N'(1));
  assign any = |req;
endmodule

// File: rtl/dwf_age.sv
module dwf_age #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] vld,
  output logic [N-1:0] oldest
);
  // older_q[i][j] set: entry i was allocated before entry j
  logic [N-1:0][N-1:0] older_q, older_d;

  always_comb begin
    older_d = older_q;
    for (int k = 0; k < N; k++) begin
      if (alloc[k]) begin
        for (int j = 0; j < N; j++) begin
          older_d[k][j] = 1'b0;
          if (j != k) older_d[j][k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else if (|alloc) older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (vld[j] && older_q[j][i]) beaten = 1'b1;
      end
      oldest[i] = vld[i] && !beaten;
    end
  end
endmodule

// File: rtl/dwf_merger.sv
module dwf_merger
  import dwf_pkg::*;
#(
  parameter int LANES   = DWF_LANES,
  parameter int ENTRIES = DWF_ENTRIES,
  parameter int PC_W    = DWF_PC_W,
  parameter int WID_W   = DWF_WID_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PC_W-1:0]        in_pc,
  input  logic [LANES-1:0]       in_mask,
  input  logic [WID_W-1:0]       in_wid,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PC_W-1:0]        out_pc,
  output logic [LANES-1:0]       out_mask,
  output logic [LANES*WID_W-1:0] out_wid
);
  localparam int WIDS_W = LANES * WID_W;

  logic [ENTRIES-1:0]                       vld_q, vld_d;
  logic [ENTRIES-1:0][PC_W-1:0]             pc_q;
  logic [ENTRIES-1:0][LANES-1:0]            mask_q;
  logic [ENTRIES-1:0][LANES-1:0][WID_W-1:0] wid_q;

  logic [ENTRIES-1:0] full_vec, full_gnt, oldest, out_sel, excl;
  logic [ENTRIES-1:0] hit_vec, hit_gnt, alloc_gnt, alloc_vec, ent_en;
  logic               any_full, any_hit, any_free, pool_full, in_zero;
  logic               in_fire, do_merge, do_alloc, out_fire;
  sel_kind_e          sel_kind;

  dwf_match #(.ENTRIES(ENTRIES), .LANES(LANES), .PC_W(PC_W)) u_match (
    .ent_vld (vld_q),
    .ent_pc  (pc_q),
    .ent_mask(mask_q),
    .excl    (excl),
    .in_pc   (in_pc),
    .in_mask (in_mask),
    .hit     (hit_vec),
    .full    (full_vec)
  );

  dwf_prio #(.N(ENTRIES)) u_full_pick (.req(full_vec), .gnt(full_gnt),  .any(any_full));
  dwf_prio #(.N(ENTRIES)) u_hit_pick  (.req(hit_vec),  .gnt(hit_gnt),   .any(any_hit));
  dwf_prio #(.N(ENTRIES)) u_free_pick (.req(~vld_q),   .gnt(alloc_gnt), .any(any_free));

  dwf_age #(.N(ENTRIES)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (alloc_vec),
    .vld   (vld_q),
    .oldest(oldest)
  );

  // Output selection: full entries first, partial entries only on drain or pressure
  assign pool_full = &vld_q;

  always_comb begin
    if (any_full)                                 sel_kind = SEL_FULL;
    else if ((pool_full || !in_valid) && |vld_q) sel_kind = SEL_OLDEST;
    else                                          sel_kind = SEL_NONE;
  end

  assign out_sel   = any_full ? full_gnt : oldest;
  assign out_valid = (sel_kind != SEL_NONE);
  assign excl      = (any_full || pool_full) ? out_sel : '0;

  always_comb begin
    out_pc   = '0;
    out_mask = '0;
    out_wid  = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (out_sel[e]) begin
        out_pc   = pc_q[e];
        out_mask = mask_q[e];
        out_wid  = WIDS_W'(wid_q[e]);
      end
    end
  end

  // Input acceptance
  assign in_zero   = ~|in_mask;
  assign in_ready  = in_zero || any_hit || any_free;
  assign in_fire   = in_valid && in_ready && !in_zero;
  assign do_merge  = in_fire && any_hit;
  assign do_alloc  = in_fire && !any_hit;
  assign out_fire  = out_valid && out_ready;
  assign alloc_vec = do_alloc ? alloc_gnt : '0;
  assign ent_en    = (do_merge ? hit_gnt : '0) | alloc_vec;

  always_comb begin
    vld_d = vld_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (out_fire && out_sel[e]) vld_d[e] = 1'b0;
      if (alloc_vec[e])           vld_d[e] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [LANES-1:0]            mask_d;
    logic [LANES-1:0][WID_W-1:0] wid_d;

    always_comb begin
      if (alloc_vec[e]) begin
        mask_d = in_mask;
        for (int l = 0; l < LANES; l++) wid_d[l] = in_mask[l] ? in_wid : '0;
      end else begin
        mask_d = mask_q[e] | in_mask;
        for (int l = 0; l < LANES; l++) wid_d[l] = in_mask[l] ? in_wid : wid_q[e][l];
      end
    end

    always_ff @(posedge clk) begin
      if (ent_en[e]) begin
        if (alloc_vec[e]) pc_q[e] <= in_pc;
        mask_q[e] <= mask_d;
        wid_q[e]  <= wid_d;
      end
    end
  end
endmodule

// File: rtl/dwf_merger_chk.sv
module dwf_merger_chk #(
  parameter int LANES   = 4,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [LANES-1:0]   in_mask,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANES-1:0]   out_mask,
  input logic [ENTRIES-1:0] ent_vld,
  input logic [ENTRIES-1:0] ent_full
);
  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld == '0) |-> !out_valid);

  a_r2_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_mask != '0) && !(out_valid && out_ready))
      |=> ($countones(ent_vld) >= $past($countones(ent_vld))));

  a_r3_out_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask != '0));

  a_r6_full_first: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (ent_full != '0)) |-> (&out_mask));

  a_r8_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (&ent_vld));

  a_r9_zero_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mask == '0)) |-> in_ready);
endmodule

bind dwf_merger dwf_merger_chk #(.LANES(LANES), .ENTRIES(ENTRIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_mask  (in_mask),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_mask (out_mask),
  .ent_vld  (vld_q),
  .ent_full (full_vec)
);

// File: tb/tb_dwf_merger.sv
`timescale 1ns/1ps
module tb_dwf_merger;
  localparam int LANES = 4;
  localparam int ENT   = 4;
  localparam int PC_W  = 16;
  localparam int WID_W = 4;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   in_valid, in_ready, out_valid, out_ready;
  logic [PC_W-1:0]        in_pc, out_pc;
  logic [LANES-1:0]       in_mask, out_mask;
  logic [WID_W-1:0]       in_wid;
  logic [LANES*WID_W-1:0] out_wid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dwf_merger #(.LANES(LANES), .ENTRIES(ENT), .PC_W(PC_W), .WID_W(WID_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc),
    .in_mask(in_mask), .in_wid(in_wid),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_mask(out_mask), .out_wid(out_wid)
  );

  function automatic logic [LANES-1:0] lane_of(input int tid);
    return LANES'(1) << (tid % LANES);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m, input logic [WID_W-1:0] w);
    in_valid = 1'b1; in_pc = pc; in_mask = m; in_wid = w;
  endtask

  task automatic idle;
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [PC_W-1:0] pc,
                            input logic [LANES-1:0] m, input logic [LANES*WID_W-1:0] w);
    #1;
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " pc"},    32'(out_pc),    32'(pc));
    check({req, " mask"},  32'(out_mask),  32'(m));
    check({req, " wid"},   32'(out_wid),   32'(w));
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready",  32'(in_ready),  32'd1);
  endtask

  // Threads 7 / 5,6 / 4 of three warps at one address fill all four lanes
  task automatic t_merge;
    drive(16'h0100, lane_of(7), 4'd1); tick();
    drive(16'h0100, lane_of(5) | lane_of(6), 4'd2);
    #1 check("R7 partial held while input busy", 32'(out_valid), 32'd0);
    tick();
    drive(16'h0100, lane_of(4), 4'd3); tick();
    idle();
    pop_expect("R2 R3 R6 merged", 16'h0100, 4'b1111, 16'h1223);
    #1 check("R10 freed after handshake", 32'(out_valid), 32'd0);
  endtask

  task automatic t_overlap;
    drive(16'h0200, 4'b0011, 4'd4); tick();
    drive(16'h0200, 4'b0010, 4'd5); tick();
    idle();
    tick(); tick();
    #1 check("R10 held without ready", 32'(out_pc), 32'h0200);
    pop_expect("R4 R7 first",  16'h0200, 4'b0011, 16'h0044);
    pop_expect("R4 second",    16'h0200, 4'b0010, 16'h0050);
  endtask

  task automatic t_diff_pc;
    drive(16'h0300, 4'b1100, 4'd6); tick();
    drive(16'h0304, 4'b0011, 4'd7); tick();
    idle();
    pop_expect("R5 pc a", 16'h0300, 4'b1100, 16'h6600);
    pop_expect("R5 pc b", 16'h0304, 4'b0011, 16'h0077);
  endtask

  task automatic t_zero;
    drive(16'h0400, 4'b0000, 4'd8);
    #1 check("R9 zero ready", 32'(in_ready), 32'd1);
    tick();
    idle();
    #1 check("R9 zero not stored", 32'(out_valid), 32'd0);
  endtask

  task automatic t_pool_full;
    for (int i = 0; i < ENT; i++) begin
      drive(16'h0500 + 16'(i), 4'b0001, 4'(i + 1)); tick();
    end
    drive(16'h0599, 4'b0001, 4'd9);
    #1 check("R8 stall when full", 32'(in_ready), 32'd0);
    check("R7 oldest offered when full", 32'(out_pc), 32'h0500);
    drive(16'h0501, 4'b0010, 4'd9);
    #1 check("R8 merge into younger", 32'(in_ready), 32'd1);
    tick();
    drive(16'h0500, 4'b0010, 4'd9);
    #1 check("R8 offered entry not a target", 32'(in_ready), 32'd0);
    idle();
    pop_expect("R7 drain e0", 16'h0500, 4'b0001, 16'h0001);
    pop_expect("R2 drain e1", 16'h0501, 4'b0011, 16'h0092);
    pop_expect("R7 drain e2", 16'h0502, 4'b0001, 16'h0003);
    pop_expect("R7 drain e3", 16'h0503, 4'b0001, 16'h0004);
  endtask

  task automatic t_full_prio;
    drive(16'h0600, 4'b0001, 4'd1); tick();
    drive(16'h0604, 4'b0111, 4'd2); tick();
    drive(16'h0604, 4'b1000, 4'd3); tick();
    idle();
    pop_expect("R6 full before oldest", 16'h0604, 4'b1111, 16'h3222);
    pop_expect("R7 then oldest",        16'h0600, 4'b0001, 16'h0001);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pc = '0; in_mask = '0; in_wid = '0; out_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_merge();
    t_overlap();
    t_diff_pc();
    t_zero();
    t_pool_full();
    t_full_prio();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule